// File: doc/BRIEF.md
# Eight-Pin Bit-Controlled GPIO with Edge Interrupts

This block manages a group of eight general-purpose I/O pins, each set up through its own control register. That register carries the pin's drive level and direction. It also holds an edge-interrupt selection, a blink-rate selection and an open-drain flag. The drive level and direction bits live in one place only. They can be reached in two ways: through the per-pin control register, or through two shared byte-wide registers (port level, port direction). A write through either path is seen at once through the other.

Pins set as inputs are synchronised and watched for the selected edge. An event latches a per-pin pending flag. While any flag is set, the block asks the pad to pull the shared interrupt line low. The status register gives the binary number of the lowest pending pin, and reading it clears that pin's flag. Pins set as outputs drive push-pull or open-drain. They can also blink in open-drain fashion: each tick of one of seven externally supplied tick inputs toggles the pin's output enable. Register access uses a plain write strobe and a combinational read port with a read strobe.

Top module: `bitctl_gpio8`

## Requirements
- R1: After reset, every register reads 0, every pin is an input with `pin_oe` low, `irq_pull` is low and the status register reads 0x00.
- R2: Register map: address 0 is port level (bit i = pin i level), address 1 is port direction (bit i = 1 makes pin i an output), address 2 is status, and addresses 8+i are the pin i control registers. In a control register, bit 0 is the level, bit 1 the direction, bits 3:2 the edge select, bits 6:4 the blink code and bit 7 the open-drain flag. A write to the level or direction bit through either path is visible through the other on the next cycle.
- R3: Edge select: 00 is off, 01 is rising, 10 is falling, 11 is both edges. An enabled edge on an input pin sets the pin's pending flag, and `irq_pull` rises on the third rising clock edge after the pin changes. Pins with direction 1, or with edge select 00, never set a flag.
- R4: `irq_pull` is high exactly while at least one pending flag is set.
- R5: The status register reads {valid in bit 7, zeros, pin number in bits 2:0}. The pin number is that of the lowest-numbered pending pin. Valid is 0 and the register reads 0x00 when nothing is pending.
- R6: A read of the status register (`rd_en` with `rd_addr` = 2) clears only the reported pin's flag. A new edge on that pin in the same cycle keeps the flag set.
- R7: An output pin with blink code 0 does not blink. Codes 1 to 7 select `flash_tick[code-1]`. While blinking, `pin_out` is 0 and `pin_oe` starts at 0 and toggles on every selected tick. Ticks on other inputs have no effect.
- R8: A non-blinking output pin drives push-pull when bit 7 is 0 (`pin_oe`=1, `pin_out`=level). When bit 7 is 1 it drives open-drain (`pin_out`=0, `pin_oe`=inverse of level). An input pin has `pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; with address 2 it clears the reported flag |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels |
| flash_tick | input | 7 | One-cycle tick pulses, one per blink rate |
| pin_out | output | 8 | Pad output value |
| pin_oe | output | 8 | Pad output enable |
| irq_pull | output | 1 | High to pull the open-drain interrupt line low |

## Verification
On every cycle, the assertions check the following. The status encoder reports a pending pin with no lower pending pin. A flag only rises on a pin that was an input with an edge select set. A status read with no competing edge removes exactly one flag. An idle blinker stays at zero. The bench scenarios are needed to show the rest: the three-cycle interrupt latency, each edge-select encoding, the shadowing between the two register paths, the drive modes, and that only the chosen tick moves a blinking pin.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  // per-pin configuration fields that are not shared with the port registers
  typedef struct packed {
    logic       odrain;
    logic [2:0] blink;
    logic [1:0] esel;
  } pin_cfg_t;
endpackage

// File: rtl/bitctl_edge_det.sv
module bitctl_edge_det (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       arm,
  input  logic [1:0] esel,
  output logic       hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    hit = arm & ((esel[0] & s2_q & ~prev_q) | (esel[1] & ~s2_q & prev_q));
  end
endmodule

// File: rtl/bitctl_blink.sv
module bitctl_blink #(
  parameter int NRATE = 7,
  parameter int CW    = $clog2(NRATE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CW-1:0]    code,
  input  logic [NRATE-1:0] tick,
  output logic             blink_q
);
  logic [NRATE:0] tick_ext;
  logic           sel_tick;

  always_comb begin
    tick_ext = {tick, 1'b0};
    sel_tick = tick_ext[code];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     blink_q <= 1'b0;
    else if (!active || code == '0) blink_q <= 1'b0;
    else if (sel_tick)              blink_q <= ~blink_q;
  end

  AST_BLINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || code == '0) |=> !blink_q); // R7
endmodule

// File: rtl/bitctl_prio_enc.sv
module bitctl_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (valid) begin
      AST_LOWEST_FIRST: assert (req[idx] && ((req & N'((1 << idx) - 1)) == '0)); // R5
    end
  end
endmodule

// File: rtl/bitctl_gpio8.sv
module bitctl_gpio8 #(
  parameter int NPIN  = 8,
  parameter int NRATE = 7,
  parameter int AW    = $clog2(2 * NPIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [bitctl_pkg::REG_W-1:0] wr_data,
  input  logic                      rd_en,
  input  logic [AW-1:0]             rd_addr,
  output logic [bitctl_pkg::REG_W-1:0] rd_data,
  input  logic [NPIN-1:0]           pin_in,
  input  logic [NRATE-1:0]          flash_tick,
  output logic [NPIN-1:0]           pin_out,
  output logic [NPIN-1:0]           pin_oe,
  output logic                      irq_pull
);
  import bitctl_pkg::*;

  localparam int IW        = $clog2(NPIN);
  localparam int CW        = $clog2(NRATE + 1);
  localparam int ADDR_LVL  = 0;
  localparam int ADDR_DIR  = 1;
  localparam int ADDR_STAT = 2;
  localparam int PIN_BASE  = NPIN;

  logic [NPIN-1:0] lvl_q, dir_q, pend_q, hit, clr, blink;
  pin_cfg_t        cfg_q [NPIN];
  logic            stat_valid, rd_clr;
  logic [IW-1:0]   stat_idx;

  // register file: level/direction stored once, reachable by two paths
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dir_q <= '0;
      for (int i = 0; i < NPIN; i++) cfg_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_LVL)) lvl_q <= wr_data[NPIN-1:0];
      if (wr_addr == AW'(ADDR_DIR)) dir_q <= wr_data[NPIN-1:0];
      for (int i = 0; i < NPIN; i++) begin
        if (wr_addr == AW'(PIN_BASE + i)) begin
          lvl_q[i] <= wr_data[0];
          dir_q[i] <= wr_data[1];
          cfg_q[i] <= wr_data[7:2];
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      bitctl_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_in[g]),
        .arm   (~dir_q[g]),
        .esel  (cfg_q[g].esel),
        .hit   (hit[g])
      );

      bitctl_blink #(.NRATE(NRATE), .CW(CW)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (dir_q[g]),
        .code    (cfg_q[g].blink),
        .tick    (flash_tick),
        .blink_q (blink[g])
      );

      always_comb begin
        if (!dir_q[g]) begin
          pin_out[g] = 1'b0;
          pin_oe[g]  = 1'b0;
        end else if (cfg_q[g].blink != '0) begin
          pin_out[g] = 1'b0;
          pin_oe[g]  = blink[g];
        end else if (cfg_q[g].odrain) begin
          pin_out[g] = 1'b0;
          pin_oe[g]  = ~lvl_q[g];
        end else begin
          pin_out[g] = lvl_q[g];
          pin_oe[g]  = 1'b1;
        end
      end

      AST_PEND_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[g] && !$past(pend_q[g])) |->
          $past(!dir_q[g] && cfg_q[g].esel != EDGE_OFF)); // R3
    end
  endgenerate

  bitctl_prio_enc #(.N(NPIN), .IW(IW)) u_enc (
    .req   (pend_q),
    .valid (stat_valid),
    .idx   (stat_idx)
  );

  always_comb begin
    rd_clr = rd_en && (rd_addr == AW'(ADDR_STAT)) && stat_valid;
    clr    = rd_clr ? (NPIN'(1) << stat_idx) : '0;
  end

  // pending flags: a new edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= hit | (pend_q & ~clr);
  end

  assign irq_pull = |pend_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_LVL))       rd_data[NPIN-1:0] = lvl_q;
    else if (rd_addr == AW'(ADDR_DIR))  rd_data[NPIN-1:0] = dir_q;
    else if (rd_addr == AW'(ADDR_STAT)) begin
      rd_data[7]    = stat_valid;
      rd_data[IW-1:0] = stat_idx;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (rd_addr == AW'(PIN_BASE + i)) rd_data = {cfg_q[i], dir_q[i], lvl_q[i]};
      end
    end
  end

  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && hit == '0) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)); // R6
endmodule

// File: tb/bitctl_gpio8_tb.sv
module bitctl_gpio8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = '0;
  logic [6:0] flash_tick = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq_pull;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bitctl_gpio8 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
    .flash_tick(flash_tick), .pin_out(pin_out), .pin_oe(pin_oe), .irq_pull(irq_pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  // status read with clear; returns the value seen before the clear
  task automatic rd_stat(output logic [7:0] d);
    @(negedge clk); rd_addr = 4'd2; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd0, d); chk("R1 level reg", d, 8'h00);
    rd(4'd1, d); chk("R1 dir reg", d, 8'h00);
    rd(4'd2, d); chk("R1 status", d, 8'h00);
    rd(4'd12, d); chk("R1 pin4 ctrl", d, 8'h00);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 irq", irq_pull, 1'b0);
  endtask

  task automatic t_shadow();
    logic [7:0] d;
    wr(4'd0, 8'hA5); wr(4'd1, 8'h0F);
    rd(4'd15, d); chk("R2 pin7 ctrl from port", d, 8'h01);
    rd(4'd8, d);  chk("R2 pin0 ctrl from port", d, 8'h03);
    wr(4'd13, 8'h02);
    rd(4'd0, d); chk("R2 port level from pin5", d, 8'h85);
    rd(4'd1, d); chk("R2 port dir from pin5", d, 8'h2F);
    wr(4'd13, 8'h00); wr(4'd0, 8'h00); wr(4'd1, 8'h00);
  endtask

  task automatic tick(input int k);
    @(negedge clk); flash_tick[k] = 1'b1;
    @(negedge clk); flash_tick[k] = 1'b0;
  endtask

  task automatic t_drive();
    wr(4'd8, 8'h03); #1;
    chk("R8 push-pull oe", pin_oe[0], 1'b1);
    chk("R8 push-pull out", pin_out[0], 1'b1);
    wr(4'd8, 8'h82); #1;
    chk("R8 open-drain low oe", pin_oe[0], 1'b1);
    chk("R8 open-drain low out", pin_out[0], 1'b0);
    wr(4'd8, 8'h83); #1;
    chk("R8 open-drain high oe", pin_oe[0], 1'b0);
    wr(4'd9, 8'h01); #1;
    chk("R8 input pin oe", pin_oe[1], 1'b0);
  endtask

  task automatic t_blink();
    wr(4'd8, 8'h33); #1;
    chk("R7 blink start oe", pin_oe[0], 1'b0);
    chk("R7 blink out", pin_out[0], 1'b0);
    tick(2); #1; chk("R7 toggle on tick3", pin_oe[0], 1'b1);
    tick(0); #1; chk("R7 other tick ignored", pin_oe[0], 1'b1);
    tick(6); #1; chk("R7 tick7 ignored", pin_oe[0], 1'b1);
    tick(2); #1; chk("R7 toggle back", pin_oe[0], 1'b0);
    wr(4'd8, 8'h03);
    tick(2); #1; chk("R7 code0 no blink", pin_oe[0], 1'b1);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wr(4'd10, 8'h04);  // pin2 rising
    @(negedge clk); pin_in[2] = 1'b1;
    idle(2); chk("R3 no irq before 3rd edge", irq_pull, 1'b0);
    idle(1); chk("R3 rising irq latency", irq_pull, 1'b1);
    chk("R4 irq while pending", irq_pull, 1'b1);
    rd_stat(d); chk("R5 status pin2", d, 8'h82);
    #1 chk("R4 irq released", irq_pull, 1'b0);
    @(negedge clk); pin_in[2] = 1'b0;
    idle(4); chk("R3 falling ignored on rise-select", irq_pull, 1'b0);
    // falling select
    wr(4'd12, 8'h08);
    @(negedge clk); pin_in[4] = 1'b1; idle(4);
    chk("R3 rising ignored on fall-select", irq_pull, 1'b0);
    @(negedge clk); pin_in[4] = 1'b0; idle(4);
    rd_stat(d); chk("R3 falling sets pin4", d, 8'h84);
    // both edges
    wr(4'd14, 8'h0C);
    @(negedge clk); pin_in[6] = 1'b1; idle(4);
    rd_stat(d); chk("R3 both rise pin6", d, 8'h86);
    @(negedge clk); pin_in[6] = 1'b0; idle(4);
    rd_stat(d); chk("R3 both fall pin6", d, 8'h86);
    // disabled select and output pin
    @(negedge clk); pin_in[7] = 1'b1; idle(4);
    chk("R3 esel 00 ignored", irq_pull, 1'b0);
    wr(4'd9, 8'h0E);
    @(negedge clk); pin_in[1] = 1'b1; idle(4);
    chk("R3 output pin ignored", irq_pull, 1'b0);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    wr(4'd11, 8'h04); wr(4'd13, 8'h04);
    @(negedge clk); pin_in[3] = 1'b1; pin_in[5] = 1'b1; idle(4);
    rd_stat(d); chk("R5 lowest first", d, 8'h83);
    #1 chk("R6 irq held by remaining flag", irq_pull, 1'b1);
    rd_stat(d); chk("R6 only pin3 cleared", d, 8'h85);
    rd(4'd2, d); chk("R6 all cleared", d, 8'h00);
    chk("R4 irq low when none", irq_pull, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(2); #1 rst_n = 1'b1;
    idle(3);
    t_reset();
    t_shadow();
    t_drive();
    t_blink();
    t_edges();
    t_prio();
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule